// File: doc/BRIEF.md
# Relative Address Counter

This block keeps a 16-bit address count for a small bus-oriented computer and turns it into a memory address by adding a signed offset. Because the offset register and the adder sit inside the block, a relative jump only needs a new offset value. The main ALU does not have to compute a new count first. The count can be reset, loaded from the shared data bus, stepped up or stepped down. It can also be presented back to the bus through a separate enable and data pair.

Any wrap raises a sticky out-of-bounds flag. This covers the count itself passing through the 0xFFFF/0x0000 boundary in either direction, and the offset addition leaving the 16-bit range. An explicit count reset also raises the flag. The flag stays set until a clear pulse, so control logic can sample it at leisure.

Top module: `aoc_addr_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count and the offset become 0 and `oobFlag` becomes 0.
- R2: `cntRst` sets the count to 0 and sets `oobFlag` at the next edge. It takes priority over every other count control.
- R3: `busLoad` without `cntRst` copies `busIn` into the count at the next edge and overrides `inc` and `dec`. A load never raises `oobFlag` by itself, even for 0xFFFF or 0x0000.
- R4: With no reset or load, `inc` alone adds one to the count, `dec` alone subtracts one, and both together hold the count.
- R5: When `readOut` is high, `busOutEn` is 1 and `busOut` equals the count in the same cycle. When `readOut` is low, both are 0.
- R6: `offLoad` copies `busIn` into the offset register at the next edge, independently of the count controls.
- R7: `addrOut` always equals the count plus the offset modulo 2^16, with no clock delay from those registers. The offset is read as a two's-complement value.
- R8: A step up from 0xFFFF to 0x0000 or a step down from 0x0000 to 0xFFFF sets `oobFlag` at that same edge.
- R9: At each edge where the true sum of the count and the signed offset is above 0xFFFF or below 0, `oobFlag` becomes set.
- R10: `oobFlag` stays set until `oobClr` is high at an edge. If a new error occurs at that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cntRst | input | 1 | Reset the count to zero (raises error) |
| busLoad | input | 1 | Load count from `busIn` |
| inc | input | 1 | Step count up |
| dec | input | 1 | Step count down |
| offLoad | input | 1 | Load offset from `busIn` |
| readOut | input | 1 | Present the count on the bus outputs |
| oobClr | input | 1 | Clear the out-of-bounds flag |
| busIn | input | 16 | Data bus input |
| busOut | output | 16 | Count value toward the bus, 0 when not enabled |
| busOutEn | output | 1 | Bus drive enable |
| addrOut | output | 16 | Count plus signed offset |
| oobFlag | output | 1 | Sticky out-of-bounds flag |

## Verification
The bench builds the block with its default 16-bit width, which is the only width the address bus uses. It does not need a narrower variant to reach the wrap points. Bus loads place the count at 0xFFFF, 0x0000 or just below the boundary in one cycle, so both count wraps can be reached directly. Loading positive and negative offsets against those counts drives the adder past either end of its range.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  // Decoded per-cycle actions handed from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic ldCnt;
    logic up;
    logic down;
    logic ldOff;
    logic clrFlag;
  } aocStrobes_t;
endpackage

// File: rtl/aoc_ctrl.sv
module aoc_ctrl
  import aoc_pkg::*;
(
  input  logic        cntRst,
  input  logic        busLoad,
  input  logic        inc,
  input  logic        dec,
  input  logic        offLoad,
  input  logic        oobClr,
  output aocStrobes_t stb
);
  // Count priority: reset, then load, then a single step; inc+dec holds
  always_comb begin
    stb.clrCnt  = cntRst;
    stb.ldCnt   = busLoad & ~cntRst;
    stb.up      = inc & ~dec & ~busLoad & ~cntRst;
    stb.down    = dec & ~inc & ~busLoad & ~cntRst;
    stb.ldOff   = offLoad;
    stb.clrFlag = oobClr;
  end
endmodule

// File: rtl/aoc_dp.sv
module aoc_dp
  import aoc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  aocStrobes_t  stb,
  input  logic [W-1:0] busIn,
  output logic [W-1:0] cntQ,
  output logic [W-1:0] offQ,
  output logic [W-1:0] addrOut,
  output logic         flagQ
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
  localparam logic [W-1:0] MIN_VAL = '0;

  logic [W:0]   sumFull;
  logic         carryOut;
  logic         adderWrap;
  logic         cntWrap;
  logic         raiseErr;
  logic [W-1:0] cntNext;

  // Offset adder: unsigned add, then interpret carry by offset sign
  assign sumFull   = {1'b0, cntQ} + {1'b0, offQ};
  assign carryOut  = sumFull[W];
  assign addrOut   = sumFull[W-1:0];
  // Positive offset wraps on carry; negative offset wraps on no carry
  assign adderWrap = offQ[W-1] ? ~carryOut : carryOut;

  assign cntWrap  = (stb.up && cntQ == MAX_VAL) || (stb.down && cntQ == MIN_VAL);
  assign raiseErr = stb.clrCnt | cntWrap | adderWrap;

  always_comb begin
    cntNext = cntQ;
    if (stb.clrCnt)     cntNext = '0;
    else if (stb.ldCnt) cntNext = busIn;
    else if (stb.up)    cntNext = cntQ + 1'b1;
    else if (stb.down)  cntNext = cntQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ  <= '0;
      offQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      cntQ <= cntNext;
      if (stb.ldOff) offQ <= busIn;
      if (raiseErr)         flagQ <= 1'b1;
      else if (stb.clrFlag) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/aoc_addr_counter.sv
module aoc_addr_counter
  import aoc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntRst,
  input  logic              busLoad,
  input  logic              inc,
  input  logic              dec,
  input  logic              offLoad,
  input  logic              readOut,
  input  logic              oobClr,
  input  logic [ADDR_W-1:0] busIn,
  output logic [ADDR_W-1:0] busOut,
  output logic              busOutEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              oobFlag
);
  aocStrobes_t       stb;
  logic [ADDR_W-1:0] cntVal;
  logic [ADDR_W-1:0] offVal;

  aoc_ctrl ctrl_i (
    .cntRst (cntRst),
    .busLoad(busLoad),
    .inc    (inc),
    .dec    (dec),
    .offLoad(offLoad),
    .oobClr (oobClr),
    .stb    (stb)
  );

  aoc_dp #(.W(ADDR_W)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .busIn  (busIn),
    .cntQ   (cntVal),
    .offQ   (offVal),
    .addrOut(addrOut),
    .flagQ  (oobFlag)
  );

  // Separate enable plus data instead of an internal tri-state
  assign busOutEn = readOut;
  assign busOut   = readOut ? cntVal : '0;
endmodule

// File: rtl/aoc_checks.sv
module aoc_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cntRst,
  input logic         busLoad,
  input logic         inc,
  input logic         dec,
  input logic         offLoad,
  input logic         readOut,
  input logic         oobClr,
  input logic [W-1:0] busIn,
  input logic [W-1:0] busOut,
  input logic         busOutEn,
  input logic         oobFlag,
  input logic [W-1:0] cntVal,
  input logic [W-1:0] offVal
);
  a_r2_reset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cntRst |=> (cntVal == '0) && oobFlag);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busLoad && !cntRst) |=> cntVal == $past(busIn));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !busLoad && !cntRst) |=> cntVal == $past(cntVal) + 1'b1);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !busLoad && !cntRst) |=> $stable(cntVal));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    !readOut |-> (!busOutEn && busOut == '0));

  a_r6_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
    offLoad |=> offVal == $past(busIn));

  a_r8_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !busLoad && !cntRst && cntVal == {W{1'b1}}) |=> oobFlag);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oobFlag && !oobClr) |=> oobFlag);
endmodule

bind aoc_addr_counter aoc_checks #(.W(ADDR_W)) checks_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cntRst  (cntRst),
  .busLoad (busLoad),
  .inc     (inc),
  .dec     (dec),
  .offLoad (offLoad),
  .readOut (readOut),
  .oobClr  (oobClr),
  .busIn   (busIn),
  .busOut  (busOut),
  .busOutEn(busOutEn),
  .oobFlag (oobFlag),
  .cntVal  (cntVal),
  .offVal  (offVal)
);

// File: tb/aoc_addr_counter_tb_top.sv
`timescale 1ns/1ps
module aoc_addr_counter_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cntRst = 1'b0, busLoad = 1'b0, inc = 1'b0, dec = 1'b0;
  logic         offLoad = 1'b0, readOut = 1'b0, oobClr = 1'b0;
  logic [W-1:0] busIn = '0;
  logic [W-1:0] busOut, addrOut;
  logic         busOutEn, oobFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Reference state, updated from the requirements
  logic [W-1:0] mCnt = '0, mOff = '0;
  logic         mFlag = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  aoc_addr_counter #(.ADDR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cntRst(cntRst), .busLoad(busLoad),
    .inc(inc), .dec(dec), .offLoad(offLoad), .readOut(readOut),
    .oobClr(oobClr), .busIn(busIn), .busOut(busOut), .busOutEn(busOutEn),
    .addrOut(addrOut), .oobFlag(oobFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock with the currently driven inputs; model follows the requirements
  task automatic cyc();
    logic signed [W+1:0] trueSum;
    logic raise;
    logic [W-1:0] nCnt;
    trueSum = $signed({2'b00, mCnt}) + $signed({{2{mOff[W-1]}}, mOff});
    raise = 1'b0;
    nCnt = mCnt;
    if (!rst_n) begin
      mCnt = '0; mOff = '0; mFlag = 1'b0;
    end else begin
      if (cntRst) begin nCnt = '0; raise = 1'b1; end
      else if (busLoad) nCnt = busIn;
      else if (inc && !dec) begin nCnt = mCnt + 1'b1; if (mCnt == '1) raise = 1'b1; end
      else if (dec && !inc) begin nCnt = mCnt - 1'b1; if (mCnt == '0) raise = 1'b1; end
      if (trueSum > 'sh0FFFF || trueSum < 0) raise = 1'b1;
      if (raise) mFlag = 1'b1;
      else if (oobClr) mFlag = 1'b0;
      if (offLoad) mOff = busIn;
      mCnt = nCnt;
    end
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cntRst = 0; busLoad = 0; inc = 0; dec = 0; offLoad = 0; oobClr = 0;
  endtask

  task automatic loadCnt(input logic [W-1:0] v);
    idle(); busLoad = 1; busIn = v; cyc(); idle();
  endtask

  task automatic loadOff(input logic [W-1:0] v);
    idle(); offLoad = 1; busIn = v; cyc(); idle();
  endtask

  task automatic clrFlag();
    idle(); oobClr = 1; cyc(); idle();
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); cyc(); cyc();
    chk("R1 addr after reset", addrOut, 16'h0000);
    chk("R1 flag after reset", oobFlag, 0);
    chk("R5 no readOut enable", busOutEn, 0);
    chk("R5 no readOut data", busOut, 0);
    rst_n = 1; cyc();
  endtask

  task automatic t_loadStep();
    readOut = 1;
    loadCnt(16'h1234);
    chk("R3 load value", busOut, 16'h1234);
    chk("R5 enable high", busOutEn, 1);
    inc = 1; cyc(); cyc(); cyc(); idle();
    chk("R4 three steps up", busOut, 16'h1237);
    dec = 1; cyc(); idle();
    chk("R4 step down", busOut, 16'h1236);
    inc = 1; dec = 1; cyc(); idle();
    chk("R4 inc+dec holds", busOut, 16'h1236);
    busLoad = 1; inc = 1; busIn = 16'h0400; cyc(); idle();
    chk("R3 load beats inc", busOut, 16'h0400);
    chk("R3 load no flag", oobFlag, mFlag);
  endtask

  task automatic t_offsetAdd();
    loadCnt(16'h1236);
    loadOff(16'h0010);
    chk("R7 positive offset", addrOut, 16'h1246);
    chk("R6 offset load count unchanged", busOut, 16'h1236);
    loadOff(16'hFFF0);
    chk("R7 negative offset", addrOut, 16'h1226);
    cyc();
    chk("R9 in-range add no flag", oobFlag, 0);
  endtask

  task automatic t_adderWrap();
    loadOff(16'h0100);
    loadCnt(16'hFF80);
    chk("R7 addr wraps modulo", addrOut, 16'h0080);
    cyc();
    chk("R9 adder overflow flag", oobFlag, 1);
    loadOff(16'h0000); clrFlag();
    chk("R10 clear works", oobFlag, 0);
    loadOff(16'hFFF0);
    loadCnt(16'h0005);
    chk("R7 negative wrap addr", addrOut, 16'hFFF5);
    cyc();
    chk("R9 adder underflow flag", oobFlag, 1);
    loadOff(16'h0000); clrFlag();
  endtask

  task automatic t_counterWrap();
    loadCnt(16'hFFFF);
    chk("R3 load of max no flag", oobFlag, 0);
    inc = 1; cyc(); idle();
    chk("R8 up wrap count", busOut, 16'h0000);
    chk("R8 up wrap flag", oobFlag, 1);
    cyc();
    chk("R10 flag sticky", oobFlag, 1);
    clrFlag();
    dec = 1; cyc(); idle();
    chk("R8 down wrap count", busOut, 16'hFFFF);
    chk("R8 down wrap flag", oobFlag, 1);
    clrFlag();
    loadCnt(16'hFFFF);
    inc = 1; oobClr = 1; cyc(); idle();
    chk("R10 raise beats clear", oobFlag, 1);
    clrFlag();
  endtask

  task automatic t_cntReset();
    loadCnt(16'h5555);
    cntRst = 1; busLoad = 1; inc = 1; busIn = 16'h7777; cyc(); idle();
    chk("R2 reset beats load", busOut, 16'h0000);
    chk("R2 reset raises flag", oobFlag, 1);
    readOut = 0; #1;
    chk("R5 released data", busOut, 0);
    chk("R5 released enable", busOutEn, 0);
  endtask

  initial begin
    t_reset();
    t_loadStep();
    t_offsetAdd();
    t_adderWrap();
    t_counterWrap();
    t_cntReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule